// File: doc/BRIEF.md
# Serial Command-Register Slave with Continuous Readout

This block is the register-access slave that sits between a four-wire serial host link and a converter core. The host drives an active-low select, a serial clock that idles high, and a data input. The slave answers on one data-out line that doubles as a ready flag. Every exchange opens with an 8-bit command byte. That byte names the target register, the direction, the converter channel, and whether the slave should stream results without further commands. The slave then shifts in an 8-bit write, or shifts out a read of 8 or 24 bits.

The slave holds the mode and filter configuration bytes and drives them to the core. It also holds the latest conversion word and its error flag, and it keeps the ready bit. The line pins are sampled on a fast system clock, and both serial clock edges are detected there. The pad is modelled as a data bit plus an output enable. While no word is being shifted, the data line shows the ready bit, low meaning a fresh result is waiting.

A run of thirty-two or more ones on the data input, counted on serial clock rises, puts the block back into its reset state. This lets a host recover after it has lost count of bits.

Top module: `sif_cmd_slave`

## Requirements
- R1: After reset the mode register reads 0x02, the filter register 0x04, the channel 0, the data word 0x000000, the ready bit is high (not ready), and a status read returns 0x8C.
- R2: The command byte arrives MSB first. Bit 7 is a zero start bit, bits 5:4 select the register, bit 3 set means read, bit 2 requests continuous read, and bits 1:0 set the channel output at the moment the command completes.
- R3: While no start bit has been seen, every data-input one sampled at a serial clock rise is ignored. The first zero begins the command, and the next seven bits complete it.
- R4: Select value 0 reads status (8 bits); on a write it only carries the command. Select 1 is mode and select 2 is filter, both 8 bits and both readable and writable. Select 3 is the 24-bit data word, which is read-only: a write to it is dropped and the slave expects a new command. Writing the mode register sets the ready bit high and clears the error bit.
- R5: On the 32nd consecutive rising serial clock edge that samples data-in high, all registers take their reset values and the slave waits for a command. Thirty-one ones followed by a zero change nothing.
- R6: The output bits change only on falling serial clock edges and are valid at the next rise. The output enable equals the inverse of select. Serial clock edges are ignored while select is high. When no word is shifting, the data line shows the ready bit.
- R7: A result strobe loads the data word and error flag and drives ready low. Completing a 24-bit read of the data word sets ready high. Outside continuous mode the same word can be read again.
- R8: Command 0x3C or 0x3D enters continuous mode. Each new result is then shifted out once on the following 24 clocks, and ready goes high after the last bit. Only a command of the form 001110xx received while ready is low leaves the mode. Any other command is ignored.
- R9: If a new result arrives while a word is still streaming in continuous mode, the streaming word is replaced and output restarts at the new word's MSB.
- R10: The status byte carries the ready bit in bit 7, the error bit in bit 6, zeros in bits 5:4, ones in bits 3:2, and the channel in bits 1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Active-low select from the host |
| sclk | input | 1 | Serial clock, idles high |
| sdi | input | 1 | Serial data from the host |
| res_valid | input | 1 | One-cycle strobe for a new conversion result |
| res_data | input | DATA_W | Conversion result word |
| res_err | input | 1 | Result was clamped at a range limit |
| sdo | output | 1 | Serial data out, or the ready bit when idle |
| sdo_en | output | 1 | Output enable for the data-out pad |
| rdy_n | output | 1 | Ready bit, low while an unread result is held |
| mode_q | output | 8 | Mode configuration byte |
| filt_q | output | 8 | Filter configuration byte |
| chan_q | output | 2 | Selected converter channel |
| cread_on | output | 1 | Continuous read mode is active |

## Verification
A slip in the bit counter or in the start-bit gate shows up within one command. The readback of a byte just written comes out shifted or lands in the wrong register, and the configuration outputs diverge from the model on the next system clock. A ready bit that is wrong appears at once on the idle data line and in the status byte. A bad continuous-mode state shows within one 24-bit word: a second copy of an old result appears, the streamed word is not restarted after a reload, or the mode does not exit. The ones counter is tested at 31 and at 32 ones, so an off-by-one there shows on the next register readback.

// File: rtl/sif_pkg.sv
package sif_pkg;
  localparam int CMD_W = 8;

  typedef enum logic [1:0] {
    ST_CMD = 2'd0,
    ST_WR  = 2'd1,
    ST_RD  = 2'd2,
    ST_CRD = 2'd3
  } sif_state_e;

  localparam logic [1:0] RS_STAT = 2'd0;
  localparam logic [1:0] RS_MODE = 2'd1;
  localparam logic [1:0] RS_FILT = 2'd2;
  localparam logic [1:0] RS_DATA = 2'd3;

  // status byte: ready, error, two zeros, two ones, channel
  function automatic logic [CMD_W-1:0] status_byte(input logic rdy_bit,
                                                  input logic err_bit,
                                                  input logic [1:0] ch);
    return {rdy_bit, err_bit, 4'b0011, ch};
  endfunction

  // leave-continuous command: 0 0 11 1 0 x x
  function automatic logic is_cread_exit(input logic [CMD_W-1:0] b);
    return b[7:2] == 6'b001110;
  endfunction
endpackage

// File: rtl/sif_edge.sv
module sif_edge #(
  parameter int ONES_LIMIT = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_n,
  input  logic sclk,
  input  logic sdi,
  output logic rise_ev,
  output logic fall_ev,
  output logic ones_hit
);
  localparam int OW = $clog2(ONES_LIMIT + 1);
  localparam logic [OW-1:0] OMAX = OW'(ONES_LIMIT);
  localparam logic [OW-1:0] OPRE = OW'(ONES_LIMIT - 1);

  logic          sclk_q;
  logic [OW-1:0] ones_cnt;

  assign rise_ev  = !sel_n && sclk && !sclk_q;
  assign fall_ev  = !sel_n && !sclk && sclk_q;
  assign ones_hit = rise_ev && sdi && (ones_cnt == OPRE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q   <= 1'b1;
      ones_cnt <= '0;
    end else begin
      sclk_q <= sclk;
      if (rise_ev) begin
        if (!sdi)                 ones_cnt <= '0;
        else if (ones_cnt != OMAX) ones_cnt <= ones_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sif_ready.sv
module sif_ready #(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              res_valid,
  input  logic [DATA_W-1:0] res_data,
  input  logic              res_err,
  input  logic              set_rdy,
  input  logic              clr_err,
  output logic [DATA_W-1:0] data_q,
  output logic              err_q,
  output logic              rdy_n
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      err_q  <= 1'b0;
      rdy_n  <= 1'b1;
    end else if (soft_rst) begin
      data_q <= '0;
      err_q  <= 1'b0;
      rdy_n  <= 1'b1;
    end else if (res_valid) begin
      data_q <= res_data;
      err_q  <= res_err;
      rdy_n  <= 1'b0;
    end else begin
      if (set_rdy) rdy_n <= 1'b1;
      if (clr_err) err_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sif_cmd_slave.sv
module sif_cmd_slave
  import sif_pkg::*;
#(
  parameter int          DATA_W     = 24,
  parameter int          ONES_LIMIT = 32,
  parameter logic [7:0]  MODE_INIT  = 8'h02,
  parameter logic [7:0]  FILT_INIT  = 8'h04
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              res_valid,
  input  logic [DATA_W-1:0] res_data,
  input  logic              res_err,
  output logic              sdo,
  output logic              sdo_en,
  output logic              rdy_n,
  output logic [7:0]        mode_q,
  output logic [7:0]        filt_q,
  output logic [1:0]        chan_q,
  output logic              cread_on
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_D = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] LAST_B = CNT_W'(CMD_W - 1);
  localparam int PAD_W = DATA_W - CMD_W;

  sif_state_e        st;
  logic              armed;
  logic [2:0]        ccnt;
  logic [5:0]        csh;
  logic [CNT_W-1:0]  bcnt;
  logic [CNT_W-1:0]  blast;
  logic [DATA_W-1:0] sh;
  logic              pend;
  logic              streaming;
  logic              rd_is_data;
  logic              wtgt_filt;
  logic [6:0]        wsh;

  // named internal events
  logic              rise_ev, fall_ev, ones_hit;
  logic              cmd_done, wr_ev, rd_last, stream_last, cread_exit;
  logic              set_rdy, clr_err, rd_active, err_q;
  logic [CMD_W-1:0]  cmd_byte, wr_val, reg_byte;
  logic [1:0]        cmd_rs;
  logic [DATA_W-1:0] data_q;

  sif_edge #(.ONES_LIMIT(ONES_LIMIT)) u_edge (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk), .sdi(sdi),
    .rise_ev(rise_ev), .fall_ev(fall_ev), .ones_hit(ones_hit)
  );

  sif_ready #(.DATA_W(DATA_W)) u_ready (
    .clk(clk), .rst_n(rst_n), .soft_rst(ones_hit),
    .res_valid(res_valid), .res_data(res_data), .res_err(res_err),
    .set_rdy(set_rdy), .clr_err(clr_err),
    .data_q(data_q), .err_q(err_q), .rdy_n(rdy_n)
  );

  assign cmd_byte    = {1'b0, csh, sdi};
  assign cmd_rs      = cmd_byte[5:4];
  assign wr_val      = {wsh, sdi};
  assign cmd_done    = rise_ev && armed && (ccnt == 3'd6) && (st == ST_CMD || st == ST_CRD);
  assign wr_ev       = rise_ev && (st == ST_WR) && (bcnt == LAST_B);
  assign rd_last     = rise_ev && (st == ST_RD) && (bcnt == blast);
  assign stream_last = rise_ev && (st == ST_CRD) && streaming && !res_valid && (bcnt == LAST_D);
  assign cread_exit  = cmd_done && (st == ST_CRD) && is_cread_exit(cmd_byte) && !rdy_n;
  assign set_rdy     = (rd_last && rd_is_data) || stream_last || (wr_ev && !wtgt_filt);
  assign clr_err     = wr_ev && !wtgt_filt;
  assign rd_active   = (st == ST_RD) || (st == ST_CRD && streaming);

  always_comb begin
    case (cmd_rs)
      RS_MODE: reg_byte = mode_q;
      RS_FILT: reg_byte = filt_q;
      default: reg_byte = status_byte(rdy_n, err_q, cmd_byte[1:0]);
    endcase
  end

  assign sdo      = rd_active ? sh[DATA_W-1] : rdy_n;
  assign sdo_en   = !sel_n;
  assign cread_on = (st == ST_CRD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_CMD; armed <= 1'b0; ccnt <= '0; csh <= '0;
      bcnt <= '0; blast <= LAST_B; sh <= '0; pend <= 1'b0;
      streaming <= 1'b0; rd_is_data <= 1'b0; wtgt_filt <= 1'b0; wsh <= '0;
      mode_q <= MODE_INIT; filt_q <= FILT_INIT; chan_q <= '0;
    end else if (ones_hit) begin
      st <= ST_CMD; armed <= 1'b0; ccnt <= '0; csh <= '0;
      bcnt <= '0; blast <= LAST_B; sh <= '0; pend <= 1'b0;
      streaming <= 1'b0; rd_is_data <= 1'b0; wtgt_filt <= 1'b0; wsh <= '0;
      mode_q <= MODE_INIT; filt_q <= FILT_INIT; chan_q <= '0;
    end else begin
      // command collector, active while idle and while streaming
      if (rise_ev && (st == ST_CMD || st == ST_CRD)) begin
        if (!armed) begin
          if (!sdi) begin
            armed <= 1'b1;
            ccnt  <= '0;
          end
        end else begin
          csh  <= {csh[4:0], sdi};
          ccnt <= ccnt + 1'b1;
          if (ccnt == 3'd6) armed <= 1'b0;
        end
      end

      case (st)
        ST_CMD: begin
          if (cmd_done) begin
            chan_q <= cmd_byte[1:0];
            if (cmd_byte[3]) begin
              if (cmd_rs == RS_DATA && cmd_byte[2]) begin
                st        <= ST_CRD;
                streaming <= 1'b0;
                pend      <= 1'b0;
              end else begin
                st         <= ST_RD;
                bcnt       <= '0;
                pend       <= 1'b0;
                rd_is_data <= (cmd_rs == RS_DATA);
                blast      <= (cmd_rs == RS_DATA) ? LAST_D : LAST_B;
                sh         <= (cmd_rs == RS_DATA) ? data_q : {reg_byte, {PAD_W{1'b0}}};
              end
            end else if (cmd_rs == RS_MODE || cmd_rs == RS_FILT) begin
              st        <= ST_WR;
              bcnt      <= '0;
              wtgt_filt <= (cmd_rs == RS_FILT);
            end
          end
        end
        ST_WR: begin
          if (rise_ev) begin
            wsh  <= wr_val[6:0];
            bcnt <= bcnt + 1'b1;
            if (wr_ev) begin
              if (wtgt_filt) filt_q <= wr_val;
              else           mode_q <= wr_val;
              st <= ST_CMD;
            end
          end
        end
        ST_RD: begin
          if (rise_ev) begin
            bcnt <= bcnt + 1'b1;
            pend <= 1'b1;
            if (rd_last) st <= ST_CMD;
          end else if (fall_ev && pend) begin
            sh   <= {sh[DATA_W-2:0], 1'b0};
            pend <= 1'b0;
          end
        end
        default: begin
          if (res_valid) begin
            sh        <= res_data;
            streaming <= 1'b1;
            bcnt      <= '0;
            pend      <= 1'b0;
          end else if (rise_ev && streaming) begin
            bcnt <= bcnt + 1'b1;
            pend <= 1'b1;
            if (stream_last) streaming <= 1'b0;
          end else if (fall_ev && pend) begin
            sh   <= {sh[DATA_W-2:0], 1'b0};
            pend <= 1'b0;
          end
          if (cread_exit) begin
            st        <= ST_CMD;
            streaming <= 1'b0;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/sif_cmd_slave_chk.sv
module sif_cmd_slave_chk #(
  parameter logic [7:0] MODE_INIT = 8'h02,
  parameter logic [7:0] FILT_INIT = 8'h04
) (
  input logic       clk,
  input logic       rst_n,
  input logic       fall_ev,
  input logic       ones_hit,
  input logic       wr_ev,
  input logic       res_valid,
  input logic       rdy_n,
  input logic       sdo,
  input logic       rd_active,
  input logic [7:0] mode_q,
  input logic [7:0] filt_q,
  input logic       cread_on
);
  assert_result_lowers_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !ones_hit |=> !rdy_n);

  assert_ones_restore_defaults_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ones_hit |=> rdy_n && mode_q == MODE_INIT && filt_q == FILT_INIT && !cread_on);

  assert_cfg_only_on_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ev && !ones_hit |=> $stable(mode_q) && $stable(filt_q));

  assert_shift_only_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_active && !fall_ev && !res_valid |=> !rd_active || $stable(sdo));

  assert_exit_needs_ready_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cread_on) |-> $past(!rdy_n) || $past(ones_hit));
endmodule

bind sif_cmd_slave sif_cmd_slave_chk #(.MODE_INIT(MODE_INIT), .FILT_INIT(FILT_INIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .fall_ev(fall_ev), .ones_hit(ones_hit), .wr_ev(wr_ev),
  .res_valid(res_valid), .rdy_n(rdy_n), .sdo(sdo), .rd_active(rd_active),
  .mode_q(mode_q), .filt_q(filt_q), .cread_on(cread_on)
);

// File: tb/tb_sif_cmd_slave.sv
module tb_sif_cmd_slave;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_n = 1'b1;
  logic        sclk = 1'b1;
  logic        sdi = 1'b0;
  logic        res_valid = 1'b0;
  logic [23:0] res_data = '0;
  logic        res_err = 1'b0;
  logic        sdo, sdo_en, rdy_n, cread_on;
  logic [7:0]  mode_q, filt_q;
  logic [1:0]  chan_q;

  int nchk = 0;
  int nfail = 0;
  bit sync_on = 1'b0;

  // reference model state
  int e_mode, e_filt, e_chan, e_rdy, e_err, e_data;

  always #5 clk = ~clk;

  sif_cmd_slave dut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk), .sdi(sdi),
    .res_valid(res_valid), .res_data(res_data), .res_err(res_err),
    .sdo(sdo), .sdo_en(sdo_en), .rdy_n(rdy_n), .mode_q(mode_q),
    .filt_q(filt_q), .chan_q(chan_q), .cread_on(cread_on)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_status(input int rdy, input int err, input int ch);
    return rdy * 128 + err * 64 + 8 + 4 + ch;
  endfunction

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R6 output enable", int'(sdo_en), int'(!sel_n));
      if (sync_on) begin
        chk("R4 mode register", int'(mode_q), e_mode);
        chk("R4 filter register", int'(filt_q), e_filt);
        chk("R2 channel", int'(chan_q), e_chan);
        chk("R7 ready bit", int'(rdy_n), e_rdy);
      end
    end
  end

  task automatic bitx(input logic b, output logic o);
    @(posedge clk); #1;
    sclk = 1'b0; sdi = b;
    repeat (3) @(posedge clk);
    #1 o = sdo;
    sclk = 1'b1;
    repeat (3) @(posedge clk);
  endtask

  task automatic xfer(input int n, input logic [23:0] din, output logic [23:0] dout);
    logic o;
    sync_on = 1'b0;
    dout = '0;
    for (int i = n - 1; i >= 0; i--) begin
      bitx(din[i], o);
      dout = {dout[22:0], o};
    end
    sdi = 1'b0;
  endtask

  task automatic reg_write(input logic [1:0] rs, input logic [7:0] val);
    logic [23:0] junk;
    xfer(8, {16'h0, 2'b00, rs, 4'b0000}, junk);
    xfer(8, {16'h0, val}, junk);
    e_chan = 0;
    if (rs == 2'd1) begin e_mode = val; e_rdy = 1; e_err = 0; end
    if (rs == 2'd2) e_filt = val;
    sync_on = 1'b1;
  endtask

  task automatic reg_read(input logic [7:0] cmd, input int n, output logic [23:0] v);
    logic [23:0] junk;
    xfer(8, {16'h0, cmd}, junk);
    e_chan = cmd[1:0];
    xfer(n, 24'h0, v);
    if (cmd[5:4] == 2'b11) e_rdy = 1;
    sync_on = 1'b1;
  endtask

  task automatic pulse(input logic [23:0] d, input logic err);
    sync_on = 1'b0;
    @(posedge clk); #1;
    res_valid = 1'b1; res_data = d; res_err = err;
    @(posedge clk); #1;
    res_valid = 1'b0;
    e_rdy = 0; e_data = d; e_err = err;
    sync_on = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [23:0] v;
    e_mode = 8'h02; e_filt = 8'h04; e_chan = 0; e_rdy = 1; e_err = 0; e_data = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1 sync_on = 1'b1;
    chk("R1 mode default", int'(mode_q), 8'h02);
    chk("R1 filter default", int'(filt_q), 8'h04);
    chk("R6 output disabled while deselected", int'(sdo_en), 0);
    sel_n = 1'b0;

    // R1 / R10 status after reset
    reg_read(8'h08, 8, v);
    chk("R1 status default", int'(v), 8'h8C);
    reg_read(8'h38, 24, v);
    chk("R1 data default", int'(v), 0);

    // R3 leading ones are held off
    sync_on = 1'b0;
    xfer(5, 24'h1F, v);
    reg_read(8'h18, 8, v);
    chk("R3 mode read after leading ones", int'(v), 8'h02);

    // R4 writes and readback
    reg_write(2'd2, 8'h55);
    reg_read(8'h28, 8, v);
    chk("R4 filter readback", int'(v), 8'h55);
    reg_write(2'd1, 8'h82);
    reg_read(8'h18, 8, v);
    chk("R4 mode readback", int'(v), 8'h82);
    sync_on = 1'b0;
    xfer(8, 24'h30, v);      // write to data register, dropped
    e_chan = 0; sync_on = 1'b1;
    reg_read(8'h28, 8, v);
    chk("R4 data write dropped, filter intact", int'(v), 8'h55);

    // R6 clocks ignored while deselected
    sel_n = 1'b1;
    xfer(8, 24'h20, v);
    xfer(8, 24'h77, v);
    sel_n = 1'b0;
    sync_on = 1'b1;
    @(posedge clk); #1;
    chk("R6 deselected write ignored", int'(filt_q), 8'h55);

    // R7 / R10 result handling
    pulse(24'hA5C3F0, 1'b0);
    @(posedge clk); #1;
    chk("R6 idle line shows ready", int'(sdo), 0);
    reg_read(8'h0A, 8, v);
    chk("R10 status with channel 2", int'(v), exp_status(0, 0, 2));
    reg_read(8'h38, 24, v);
    chk("R7 data read", int'(v), 24'hA5C3F0);
    chk("R7 ready high after data read", int'(rdy_n), 1);
    reg_read(8'h38, 24, v);
    chk("R7 data re-read", int'(v), 24'hA5C3F0);
    pulse(24'h000001, 1'b1);
    reg_read(8'h08, 8, v);
    chk("R10 status error set", int'(v), exp_status(0, 1, 0));
    reg_write(2'd1, 8'h02);
    reg_read(8'h08, 8, v);
    chk("R4 mode write sets ready clears error", int'(v), exp_status(1, 0, 0));

    // R8 continuous read
    sync_on = 1'b0;
    xfer(8, 24'h3C, v);
    e_chan = 0; sync_on = 1'b1;
    chk("R8 continuous mode entered", int'(cread_on), 1);
    pulse(24'h123456, 1'b0);
    xfer(24, 24'h0, v);
    sync_on = 1'b1;
    chk("R8 streamed word", int'(v), 24'h123456);
    e_rdy = 1;
    chk("R8 ready high after stream", int'(rdy_n), 1);
    xfer(24, 24'h0, v);
    sync_on = 1'b1;
    chk("R8 word streamed only once", int'(v), 24'hFFFFFF);

    // R9 reload mid-stream
    pulse(24'h0F0F0F, 1'b0);
    xfer(8, 24'h0, v);
    chk("R9 partial first word", int'(v), 8'h0F);
    pulse(24'hABCDEF, 1'b0);
    xfer(24, 24'h0, v);
    e_rdy = 1; sync_on = 1'b1;
    chk("R9 reloaded word from MSB", int'(v), 24'hABCDEF);

    // R8 exit rules
    xfer(8, 24'h38, v);
    sync_on = 1'b1;
    chk("R8 exit ignored while ready high", int'(cread_on), 1);
    pulse(24'h000111, 1'b0);
    xfer(8, 24'h38, v);
    sync_on = 1'b1;
    chk("R8 stream bits during exit", int'(v), 8'h00);
    chk("R8 exit while ready low", int'(cread_on), 0);
    reg_read(8'h38, 24, v);
    chk("R7 data after exit", int'(v), 24'h000111);

    // R5 thirty-one ones then a command: no reset
    reg_write(2'd2, 8'h33);
    reg_read(8'h28, 8, v);
    sync_on = 1'b0;
    xfer(24, 24'hFFFFFF, v);
    xfer(7, 24'h7F, v);
    sync_on = 1'b1;
    reg_read(8'h28, 8, v);
    chk("R5 thirty-one ones keep filter", int'(v), 8'h33);

    // R5 thirty-two ones reset the part
    reg_write(2'd1, 8'h42);
    pulse(24'h777777, 1'b1);
    reg_read(8'h08, 8, v);
    sync_on = 1'b0;
    xfer(24, 24'hFFFFFF, v);
    xfer(8, 24'hFF, v);
    e_mode = 8'h02; e_filt = 8'h04; e_chan = 0; e_rdy = 1; e_err = 0; e_data = 0;
    sync_on = 1'b1;
    @(posedge clk); #1;
    chk("R5 mode restored", int'(mode_q), 8'h02);
    reg_read(8'h08, 8, v);
    chk("R5 status restored", int'(v), 8'h8C);
    reg_read(8'h38, 24, v);
    chk("R5 data cleared", int'(v), 0);

    sync_on = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule